// File: doc/BRIEF.md
# Multi-Context Isochronous Transmit DMA

This block feeds the transmit FIFO of an isochronous link from host memory. Each time a cycle-start strobe arrives it makes one scan over its eight transmit contexts, lowest index first. A context whose enable bit is clear is passed over without any memory traffic. For an enabled context the block reads a two-word descriptor from the address held in that context's pointer input. The first word carries a 16-bit byte count in its low half and a 16-bit channel/tag value in its high half. The second word is the payload address. The block pushes the first word into the FIFO as a packet header, then fetches the payload, rounded up to whole 32-bit words, and pushes it in address order.

When the scan has passed the last context, a cycle-end marker word is written with a sideband flag set, so the consumer knows nothing more belongs to this cycle. Memory is reached through a request/grant read port. The block holds a request, waits for the grant, then takes data beats under a valid/ready handshake. A full FIFO stalls the writer. No word is lost. A strobe that lands while a scan is in progress is remembered, and one more scan begins once the marker is out.

Top module: `itx_dma`

## Requirements
- R1: After reset `mem_req` and `fifo_wr` are low, and no FIFO write or memory request occurs until `cycle_start` is seen.
- R2: A scan visits contexts in ascending index order (0 first) and processes each enabled context exactly once. A context whose `ctx_enable` bit is 0 causes no memory request and no FIFO word.
- R3: For an enabled context the first request has `mem_addr` equal to that context's pointer (bits [32*i+31:32*i] of `ctx_desc_ptr`) and `mem_words` equal to 2. Returned beat 0 is {tag[31:16], byte count[15:0]} and beat 1 is the payload address.
- R4: Each processed context first writes descriptor word 0 unchanged into the FIFO as a header word with `fifo_mark` = 0.
- R5: The payload is read with one request of ceil(byte count / 4) words starting at the payload address, and each word goes to the FIFO in order with `fifo_mark` = 0. A byte count of 0 gives no payload request.
- R6: Every scan ends with exactly one marker write: `fifo_wdata` = 32'hFFFF_FFFF with `fifo_mark` = 1. No other write has `fifo_mark` = 1.
- R7: `fifo_wr` is never high while `fifo_full` is high. During the payload phase `mem_rready` drops while the FIFO is full. Every accepted payload beat reaches the FIFO.
- R8: Once raised, `mem_req`, `mem_addr` and `mem_words` hold steady until `mem_gnt` is seen.
- R9: A `cycle_start` arriving during a scan starts exactly one further scan after the marker is written. Several such strobes collapse into one.
- R10: From idle, with `cycle_start` sampled at clock edge E0, the output of the first step is valid after edge E1. That output is `mem_req` for the first enabled context, or the marker write when no context is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_start | input | 1 | One-cycle strobe opening an isochronous cycle |
| ctx_enable | input | 8 | Per-context enable |
| ctx_desc_ptr | input | 256 | Per-context descriptor address, context i in bits [32i+31:32i] |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Start byte address of the read |
| mem_words | output | 15 | Number of 32-bit words to read |
| mem_gnt | input | 1 | One-cycle grant of the pending request |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| mem_rready | output | 1 | Block accepts the current beat |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |
| fifo_mark | output | 1 | Sideband flag, high only on the cycle-end marker |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |

## Verification
The latency checks follow R10. The strobe is driven for one cycle, so it is sampled at edge E0, and the bench samples one negative edge after E1. At that point `mem_req` with the first context's pointer is expected, or, when every context is disabled, a marker write. Everything later depends on grant and beat timing. The bench therefore checks order and content instead of cycle numbers. It logs every granted request and every FIFO write, 1 ns before the edge that acts on it. Once a fixed settling window has passed, it compares these logs with streams built from the context settings. Stalls from a toggling full flag and delayed grants shift the timing but must leave those streams unchanged.

// File: rtl/itx_pkg.sv
// Shared types for the isochronous transmit DMA.
// Assumes 32-bit FIFO words; the marker pattern is reserved and never used
// as a header value by software.
package itx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_DREQ,
        ST_DRD0,
        ST_DRD1,
        ST_HDR,
        ST_PREQ,
        ST_PDAT,
        ST_MARK
    } itx_state_e;

    typedef enum logic [1:0] {
        SRC_HDR,
        SRC_DATA,
        SRC_MARK
    } itx_src_e;

    localparam logic [31:0] ITX_MARK_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/itx_ctx_pick.sv
// Finds the lowest-numbered enabled context at or above a base index.
// Purely combinational. base may equal NUM_CTX, which means nothing is left.
module itx_ctx_pick #(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = $clog2(NUM_CTX),
    parameter int BASE_W  = IDX_W + 1
) (
    input  logic [NUM_CTX-1:0] enable,
    input  logic [BASE_W-1:0]  base,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_CTX-1:0] eligible;

    // One eligibility bit per context: enabled and not yet passed in this scan
    for (genvar g = 0; g < NUM_CTX; g++) begin : g_elig
        assign eligible[g] = enable[g] && (BASE_W'(g) >= base);
    end

    // Priority selection toward the lowest eligible index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CTX - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/itx_beat_ctr.sv
// Counts the payload beats still owed by the current data read.
// Assumes load is never asserted together with dec.
module itx_beat_ctr #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    // Load the request length, then count accepted beats down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/itx_fifo_mux.sv
// Selects the word presented to the transmit FIFO: header, payload or marker.
module itx_fifo_mux #(
    parameter int DATA_W = 32
) (
    input  itx_pkg::itx_src_e  sel,
    input  logic [DATA_W-1:0]  hdr_word,
    input  logic [DATA_W-1:0]  data_word,
    input  logic [DATA_W-1:0]  mark_word,
    output logic [DATA_W-1:0]  wdata
);
    // Word source selection
    always_comb begin
        unique case (sel)
            itx_pkg::SRC_HDR:  wdata = hdr_word;
            itx_pkg::SRC_DATA: wdata = data_word;
            default:           wdata = mark_word;
        endcase
    end
endmodule

// File: rtl/itx_dma.sv
// Multi-context isochronous transmit DMA.
// On each cycle-start strobe it scans the contexts in ascending order. For each
// enabled one it reads a 2-word descriptor, writes descriptor word 0 to the
// FIFO as a header, then reads ceil(bytes/4) payload words into the FIFO.
// It ends the scan with a flagged marker word.
// Assumes: mem_gnt pulses once per request; beats follow the grant and are
// taken when mem_rvalid && mem_rready; pointers and enables are steady
// while a context is being processed.
module itx_dma #(
    parameter int                 NUM_CTX   = 8,
    parameter int                 ADDR_W    = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 LEN_W     = 16,
    parameter logic [DATA_W-1:0]  MARK_WORD = itx_pkg::ITX_MARK_WORD,
    parameter int                 IDX_W     = $clog2(NUM_CTX),
    parameter int                 WCNT_W    = LEN_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cycle_start,
    input  logic [NUM_CTX-1:0]        ctx_enable,
    input  logic [NUM_CTX*ADDR_W-1:0] ctx_desc_ptr,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [WCNT_W-1:0]         mem_words,
    input  logic                      mem_gnt,
    input  logic                      mem_rvalid,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      mem_rready,
    output logic                      fifo_wr,
    output logic [DATA_W-1:0]         fifo_wdata,
    output logic                      fifo_mark,
    input  logic                      fifo_full
);
    import itx_pkg::*;

    localparam int BASE_W = IDX_W + 1;

    itx_state_e         st;
    logic [BASE_W-1:0]  base;
    logic [IDX_W-1:0]   cur;
    logic [DATA_W-1:0]  hdr_word;
    logic [ADDR_W-1:0]  data_addr;
    logic               pending;

    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic [LEN_W:0]     byte_sum;
    logic [WCNT_W-1:0]  nwords;
    logic               data_phase;
    logic               beat;
    logic               beat_last;
    logic               start_scan;
    logic [ADDR_W-1:0]  cur_ptr;
    itx_src_e           src_sel;

    // Next enabled context at or above the scan base
    itx_ctx_pick #(
        .NUM_CTX (NUM_CTX),
        .IDX_W   (IDX_W),
        .BASE_W  (BASE_W)
    ) u_pick (
        .enable (ctx_enable),
        .base   (base),
        .found  (pick_found),
        .idx    (pick_idx)
    );

    // Byte count rounded up to whole words
    always_comb begin
        byte_sum = {1'b0, hdr_word[LEN_W-1:0]} + (LEN_W+1)'(3);
        nwords   = WCNT_W'(byte_sum >> 2);
    end

    assign cur_ptr    = ctx_desc_ptr[cur*ADDR_W +: ADDR_W];
    assign data_phase = (st == ST_PDAT);
    assign beat       = data_phase && mem_rvalid && !fifo_full;
    assign start_scan = (st == ST_IDLE) && (cycle_start || pending);

    // Payload beat counter for the data read
    itx_beat_ctr #(
        .CNT_W (WCNT_W)
    ) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st == ST_PREQ && mem_gnt),
        .load_val (nwords),
        .dec      (beat),
        .last     (beat_last)
    );

    // Memory request port drive
    always_comb begin
        mem_req    = (st == ST_DREQ) || (st == ST_PREQ);
        mem_addr   = (st == ST_DREQ) ? cur_ptr : data_addr;
        mem_words  = (st == ST_DREQ) ? WCNT_W'(2) : nwords;
        mem_rready = (st == ST_DRD0) || (st == ST_DRD1) || (data_phase && !fifo_full);
    end

    // FIFO write strobe and source choice
    always_comb begin
        fifo_wr   = 1'b0;
        src_sel   = SRC_MARK;
        fifo_mark = 1'b0;
        case (st)
            ST_HDR: begin
                fifo_wr = !fifo_full;
                src_sel = SRC_HDR;
            end
            ST_PDAT: begin
                fifo_wr = mem_rvalid && !fifo_full;
                src_sel = SRC_DATA;
            end
            ST_MARK: begin
                fifo_wr   = !fifo_full;
                fifo_mark = 1'b1;
            end
            default: ;
        endcase
    end

    itx_fifo_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .sel       (src_sel),
        .hdr_word  (hdr_word),
        .data_word (mem_rdata),
        .mark_word (MARK_WORD),
        .wdata     (fifo_wdata)
    );

    // Remember a strobe that arrives while a scan is under way
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (start_scan) begin
            pending <= 1'b0;
        end else if (cycle_start && st != ST_IDLE) begin
            pending <= 1'b1;
        end
    end

    // Scan sequencer: select, descriptor, header, payload, marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            base      <= '0;
            cur       <= '0;
            hdr_word  <= '0;
            data_addr <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_scan) begin
                        base <= '0;
                        st   <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    if (pick_found) begin
                        cur <= pick_idx;
                        st  <= ST_DREQ;
                    end else begin
                        st  <= ST_MARK;
                    end
                end
                ST_DREQ: begin
                    if (mem_gnt) st <= ST_DRD0;
                end
                ST_DRD0: begin
                    if (mem_rvalid) begin
                        hdr_word <= mem_rdata;
                        st       <= ST_DRD1;
                    end
                end
                ST_DRD1: begin
                    if (mem_rvalid) begin
                        data_addr <= ADDR_W'(mem_rdata);
                        st        <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (!fifo_full) begin
                        if (nwords == '0) begin
                            base <= BASE_W'(cur) + BASE_W'(1);
                            st   <= ST_SELECT;
                        end else begin
                            st   <= ST_PREQ;
                        end
                    end
                end
                ST_PREQ: begin
                    if (mem_gnt) st <= ST_PDAT;
                end
                ST_PDAT: begin
                    if (beat && beat_last) begin
                        base <= BASE_W'(cur) + BASE_W'(1);
                        st   <= ST_SELECT;
                    end
                end
                ST_MARK: begin
                    if (!fifo_full) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/itx_dma_chk.sv
// Property checker for itx_dma, attached through bind.
module itx_dma_chk #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                WCNT_W    = 15,
    parameter logic [DATA_W-1:0] MARK_WORD = itx_pkg::ITX_MARK_WORD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WCNT_W-1:0] mem_words,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              mem_rready,
    input logic              fifo_wr,
    input logic [DATA_W-1:0] fifo_wdata,
    input logic              fifo_mark,
    input logic              fifo_full,
    input logic              data_phase
);
    // R1: quiet ports in the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req && !fifo_wr));

    // R7: never write into a full FIFO
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    // R7: every accepted payload beat is written as data
    assert_beat_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && mem_rvalid && mem_rready) |-> (fifo_wr && !fifo_mark));

    // R8: request fields steady until granted
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_words)));

    // R5: no zero-length read is ever requested
    assert_req_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_words != '0));

    // R6: the flagged word is always the reserved marker pattern
    assert_marker_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_mark) |-> (fifo_wdata == MARK_WORD));
endmodule

bind itx_dma itx_dma_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WCNT_W    (WCNT_W),
    .MARK_WORD (MARK_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_words  (mem_words),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rready (mem_rready),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .fifo_mark  (fifo_mark),
    .fifo_full  (fifo_full),
    .data_phase (data_phase)
);

// File: tb/itx_dma_tb.sv
// Directed bench for itx_dma: behavioural memory, FIFO logger, one task per scenario.
module itx_dma_tb;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cycle_start = 1'b0;
    logic [NC-1:0] ctx_enable = '0;
    logic [NC*32-1:0] ctx_desc_ptr;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic [14:0]   mem_words;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          mem_rready;
    logic          fifo_wr;
    logic [31:0]   fifo_wdata;
    logic          fifo_mark;
    logic          fifo_full = 1'b0;

    int checks = 0;
    int bad = 0;

    logic [15:0] cfg_bytes [NC];
    logic [15:0] cfg_tag   [NC];

    logic [31:0] got_w [1024];
    logic        got_m [1024];
    int          got_n = 0;
    logic [31:0] exp_w [1024];
    logic        exp_m [1024];
    int          exp_n = 0;
    logic [31:0] rq_a  [256];
    int          rq_w  [256];
    int          rq_n = 0;
    logic [31:0] xq_a  [256];
    int          xq_w  [256];
    int          xq_n = 0;
    int          req_unstable = 0;
    int          gnt_delay = 0;
    bit          full_mode = 1'b0;
    int          cyc = 0;

    always #5 clk = ~clk;

    itx_dma u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cycle_start  (cycle_start),
        .ctx_enable   (ctx_enable),
        .ctx_desc_ptr (ctx_desc_ptr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_words    (mem_words),
        .mem_gnt      (mem_gnt),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .mem_rready   (mem_rready),
        .fifo_wr      (fifo_wr),
        .fifo_wdata   (fifo_wdata),
        .fifo_mark    (fifo_mark),
        .fifo_full    (fifo_full)
    );

    function automatic logic [31:0] ptr_of(int c);
        return 32'h0000_1000 + 32'(c * 16);
    endfunction

    function automatic logic [31:0] daddr_of(int c);
        return 32'h0010_0000 + 32'(c * 32'h1000);
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        int c;
        if (a[31:12] == 20'h00001) begin
            c = int'(a[6:4]);
            return a[2] ? daddr_of(c) : {cfg_tag[c], cfg_bytes[c]};
        end
        return a ^ 32'h5A5A_0000;
    endfunction

    initial begin
        for (int c = 0; c < NC; c++) ctx_desc_ptr[c*32 +: 32] = ptr_of(c);
    end

    // Full-flag pattern generator
    initial forever begin
        @(negedge clk);
        cyc++;
        fifo_full = full_mode && ((cyc % 3) == 1);
    end

    // Memory model: grant after a delay, then stream beats under rready
    initial begin
        logic [31:0] m_addr;
        int m_words;
        forever begin
            @(negedge clk); #4;
            if (rst_n && mem_req) begin
                m_addr  = mem_addr;
                m_words = int'(mem_words);
                repeat (gnt_delay) begin
                    @(negedge clk); #4;
                    if (!mem_req || mem_addr != m_addr || int'(mem_words) != m_words)
                        req_unstable++;
                end
                @(negedge clk);
                mem_gnt = 1'b1;
                rq_a[rq_n] = m_addr;
                rq_w[rq_n] = m_words;
                rq_n++;
                @(negedge clk);
                mem_gnt = 1'b0;
                for (int i = 0; i < m_words; i++) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_word(m_addr + 32'(4 * i));
                    #4;
                    while (!mem_rready) begin
                        @(negedge clk); #4;
                    end
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // FIFO write logger, sampled just before the capturing edge
    initial forever begin
        @(negedge clk); #4;
        if (fifo_wr) begin
            got_w[got_n] = fifo_wdata;
            got_m[got_n] = fifo_mark;
            got_n++;
        end
    end

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic clear_logs();
        got_n = 0; exp_n = 0; rq_n = 0; xq_n = 0; req_unstable = 0;
    endtask

    // Expected stream and request log for one scan of the current setup
    task automatic add_scan();
        int nw;
        for (int c = 0; c < NC; c++) begin
            if (ctx_enable[c]) begin
                xq_a[xq_n] = ptr_of(c); xq_w[xq_n] = 2; xq_n++;
                exp_w[exp_n] = {cfg_tag[c], cfg_bytes[c]}; exp_m[exp_n] = 1'b0; exp_n++;
                nw = (int'(cfg_bytes[c]) + 3) / 4;
                if (nw > 0) begin
                    xq_a[xq_n] = daddr_of(c); xq_w[xq_n] = nw; xq_n++;
                end
                for (int i = 0; i < nw; i++) begin
                    exp_w[exp_n] = (daddr_of(c) + 32'(4 * i)) ^ 32'h5A5A_0000;
                    exp_m[exp_n] = 1'b0;
                    exp_n++;
                end
            end
        end
        exp_w[exp_n] = 32'hFFFF_FFFF; exp_m[exp_n] = 1'b1; exp_n++;
    endtask

    task automatic compare_stream(string tag);
        check(got_n == exp_n, tag, "fifo word count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_w[i] == exp_w[i], tag, $sformatf("fifo word %0d", i), got_w[i], exp_w[i]);
            check(got_m[i] == exp_m[i], tag, $sformatf("mark bit %0d", i), got_m[i], exp_m[i]);
        end
    endtask

    task automatic compare_reqs(string tag);
        check(rq_n == xq_n, tag, "request count", rq_n, xq_n);
        for (int i = 0; i < xq_n && i < rq_n; i++) begin
            check(rq_a[i] == xq_a[i], tag, $sformatf("request %0d addr", i), rq_a[i], xq_a[i]);
            check(rq_w[i] == xq_w[i], tag, $sformatf("request %0d words", i), rq_w[i], xq_w[i]);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); cycle_start = 1'b1;
        @(negedge clk); cycle_start = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state and silence without a strobe
    task automatic t_reset();
        @(negedge clk); #4;
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        check(fifo_wr == 1'b0, "R1", "fifo_wr after reset", fifo_wr, 0);
        ctx_enable = 8'hFF;
        wait_cycles(20);
        check(got_n == 0, "R1", "writes with no strobe", got_n, 0);
        check(rq_n == 0, "R1", "requests with no strobe", rq_n, 0);
        ctx_enable = '0;
    endtask

    // R2 R6 R10: empty scan gives only the marker, one edge after E0
    task automatic t_empty();
        clear_logs();
        ctx_enable = '0;
        pulse_start();
        @(negedge clk); #4;
        check(fifo_wr && fifo_mark, "R10", "marker write after E1", {fifo_wr, fifo_mark}, 2'b11);
        wait_cycles(20);
        add_scan();
        compare_stream("R6");
        check(rq_n == 0, "R2", "requests with all disabled", rq_n, 0);
    endtask

    // R3 R4 R5 R10: one context, first request timing and contents
    task automatic t_single();
        clear_logs();
        ctx_enable = 8'h01;
        cfg_bytes[0] = 16'd8; cfg_tag[0] = 16'h0012;
        pulse_start();
        @(negedge clk); #4;
        check(mem_req == 1'b1, "R10", "mem_req after E1", mem_req, 1);
        check(mem_addr == ptr_of(0), "R3", "descriptor address", mem_addr, ptr_of(0));
        check(mem_words == 15'd2, "R3", "descriptor length", mem_words, 2);
        wait_cycles(60);
        add_scan();
        compare_stream("R4");
        compare_reqs("R5");
    endtask

    // R2 R5: sparse enables, odd and zero byte counts
    task automatic t_mixed();
        clear_logs();
        ctx_enable = 8'b0100_1010;
        cfg_bytes[1] = 16'd5;  cfg_tag[1] = 16'h0101;
        cfg_bytes[3] = 16'd0;  cfg_tag[3] = 16'h0303;
        cfg_bytes[6] = 16'd13; cfg_tag[6] = 16'h0606;
        pulse_start();
        wait_cycles(120);
        add_scan();
        compare_stream("R5");
        compare_reqs("R2");
    endtask

    // R7 R8: every context, FIFO full toggling, delayed grants
    task automatic t_full();
        clear_logs();
        ctx_enable = 8'hFF;
        for (int c = 0; c < NC; c++) begin
            cfg_bytes[c] = 16'(c * 4 + 3);
            cfg_tag[c]   = 16'(16'hA000 + c);
        end
        full_mode = 1'b1;
        gnt_delay = 2;
        pulse_start();
        wait_cycles(600);
        full_mode = 1'b0;
        gnt_delay = 0;
        add_scan();
        compare_stream("R7");
        compare_reqs("R2");
        check(req_unstable == 0, "R8", "request changed before grant", req_unstable, 0);
    endtask

    // R9: strobes during a scan yield exactly one more scan
    task automatic t_pending();
        int marks;
        clear_logs();
        ctx_enable = 8'h01;
        cfg_bytes[0] = 16'd40; cfg_tag[0] = 16'h0F0F;
        pulse_start();
        wait_cycles(3);
        pulse_start();
        wait_cycles(2);
        pulse_start();
        wait_cycles(200);
        add_scan();
        add_scan();
        marks = 0;
        for (int i = 0; i < got_n; i++) if (got_m[i]) marks++;
        check(marks == 2, "R9", "markers after pending strobes", marks, 2);
        compare_stream("R9");
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            cfg_bytes[c] = '0;
            cfg_tag[c]   = '0;
        end
        wait_cycles(4);
        rst_n = 1'b1;
        t_reset();
        t_empty();
        t_single();
        t_mixed();
        t_full();
        t_pending();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule